// File: doc/BRIEF.md
# Software Power-Down and Wake Controller

This block owns the system power-enable line of a battery-backed timekeeping device. Software turns the system off by writing a power-off control bit. The block then releases its open-drain power-enable output. The output is modelled as a drive-low request: 1 means the pin is pulled low and system power is on, and 0 means the pin is released.

Two event sources can turn power back on:
- a one-cycle alarm-match pulse from the clock logic;
- a falling edge on an active-low kickstart pin, which is synchronized inside the block.

Each event always latches its own status flag. When the matching enable bit is set, the event also drives power back on and contributes to the interrupt request. The interrupt request is likewise modelled as a drive-low request. It also merges an interrupt request from other sources in the device, and it is released whenever the main supply is not good.

Software uses a small byte-wide port with a one-bit address. Writes are registered. Reads are combinational from the selected register.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset, `pwr_drive_low` is 1, `irq_drive_low` is 0, and both registers read 0x00.
- R2: A write to address 0 with bit 3 set releases power: after that clock edge, `pwr_drive_low` is 0 and address 0 bit 3 reads 1. This holds unless an enabled event occurs in the same cycle.
- R3: An enabled wake or kickstart event drives `pwr_drive_low` to 1 after the edge at which it is taken, whatever the prior state. The same edge clears address 0 bit 3 to 0. Writing 0 to bit 3 has no effect.
- R4: An alarm pulse sets the wake flag (address 0 bit 1), and a kickstart event sets the kickstart flag (address 0 bit 0). Both flags are set whether or not the source is enabled. A disabled event leaves `pwr_drive_low` unchanged.
- R5: Writing 0 to a flag bit at address 0 clears that flag. Writing 1 to a flag bit has no effect. When an event and a clearing write reach the same flag in the same cycle, the flag is set.
- R6: `irq_drive_low` is 1 exactly when `supply_ok` is 1 and at least one of these holds:
  - the wake flag and the wake enable are both set;
  - the kickstart flag and the kickstart enable are both set;
  - `other_irq` is 1.
- R7: While `supply_ok` is 0, `irq_drive_low` is 0, but flags, enables and power re-assertion keep working.
- R8: `kick_n` passes through two synchronizer flops. A low level first sampled at edge k sets the kickstart flag after edge k+2. Holding the pin low raises no further event, and a rising edge raises none.
- R9: Address 1 holds the enables: bit 1 is the wake enable and bit 0 is the kickstart enable. Both are written directly. The other bits of address 1, and bits 7:4 and 2 of address 0, read 0.
- R10: When an enabled event and a power-off write fall in the same cycle, the event wins: `pwr_drive_low` stays 1 and bit 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply above power-fail threshold |
| bus_wr | input | 1 | Write strobe, sampled at clock edge |
| bus_addr | input | 1 | Register select: 0 control/status, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| kick_n | input | 1 | Asynchronous active-low kickstart pin |
| other_irq | input | 1 | Interrupt request from other sources |
| pwr_drive_low | output | 1 | 1 pulls the power-enable pin low (power on), 0 releases it |
| irq_drive_low | output | 1 | 1 pulls the interrupt pin low, 0 releases it |

## Verification
Register effects of writes and alarm pulses appear one edge after the cycle that carries them. A kickstart low level takes three edges to reach the flag, because it passes two synchronizer flops and then an edge detector. Read data and the interrupt output follow their inputs within the same cycle. The bench drives every input at the falling clock edge and runs a behavioural model at the rising edge, using the same synchronizer delay. One time unit after each input change, it compares the power, interrupt and read-data outputs against that model, so registered and combinational results are both checked in the cycle they become due.

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              alarm_hit,
  input  logic              kick_n,
  input  logic              other_irq,
  output logic              pwr_drive_low,
  output logic              irq_drive_low
);
  localparam int OFF_BIT  = 3;
  localparam int WAKE_BIT = 1;
  localparam int KICK_BIT = 0;

  logic [SYNC_STAGES:0] kick_sync;
  logic pwr_on, wake_flag, kick_flag, wake_en, kick_en;

  wire kick_fall = kick_sync[SYNC_STAGES] & ~kick_sync[SYNC_STAGES-1];
  wire wr_ctrl   = bus_wr & ~bus_addr;
  wire wr_en_reg = bus_wr &  bus_addr;
  wire evt_on    = (alarm_hit & wake_en) | (kick_fall & kick_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) kick_sync <= '1;
    else        kick_sync <= {kick_sync[SYNC_STAGES-1:0], kick_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          pwr_on <= 1'b1;
    else if (evt_on)                     pwr_on <= 1'b1;
    else if (wr_ctrl && bus_wdata[OFF_BIT]) pwr_on <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_flag <= 1'b0;
      kick_flag <= 1'b0;
    end else begin
      if (alarm_hit)                                wake_flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[WAKE_BIT])     wake_flag <= 1'b0;
      if (kick_fall)                                kick_flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[KICK_BIT])     kick_flag <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_en <= 1'b0;
      kick_en <= 1'b0;
    end else if (wr_en_reg) begin
      wake_en <= bus_wdata[WAKE_BIT];
      kick_en <= bus_wdata[KICK_BIT];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata[WAKE_BIT] = wake_en;
      bus_rdata[KICK_BIT] = kick_en;
    end else begin
      bus_rdata[OFF_BIT]  = ~pwr_on;
      bus_rdata[WAKE_BIT] = wake_flag;
      bus_rdata[KICK_BIT] = kick_flag;
    end
  end

  assign pwr_drive_low = pwr_on;
  assign irq_drive_low = supply_ok & ((wake_flag & wake_en) | (kick_flag & kick_en) | other_irq);

  a_r2_off_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[OFF_BIT] && !evt_on) |=> !pwr_drive_low);

  a_r3_wake_on: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && wake_en) |=> (pwr_drive_low && !bus_rdata[OFF_BIT] || bus_addr));

  a_r4_alarm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> wake_flag);

  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !(wr_ctrl && !bus_wdata[WAKE_BIT])) |=> wake_flag);

  a_r8_kick_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(kick_sync[SYNC_STAGES-1]) && kick_sync[SYNC_STAGES]) |=> kick_flag);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((kick_fall && kick_en) && wr_ctrl && bus_wdata[OFF_BIT]) |=> pwr_drive_low);
endmodule

// File: tb/test_pwr_wake_ctl.sv
module test_pwr_wake_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic alarm_hit = 1'b0, kick_n = 1'b1, other_irq = 1'b0;
  logic [7:0] bus_rdata;
  logic pwr_drive_low, irq_drive_low;

  int checks = 0, errors = 0;
  bit m_pwr, m_wf, m_kf, m_we, m_ke;
  bit k1, k2, k3;

  always #5 clk = ~clk;

  pwr_wake_ctl i_pwr_wake_ctl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_hit(alarm_hit), .kick_n(kick_n), .other_irq(other_irq),
    .pwr_drive_low(pwr_drive_low), .irq_drive_low(irq_drive_low)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 1; m_wf = 0; m_kf = 0; m_we = 0; m_ke = 0;
      k1 = 1; k2 = 1; k3 = 1;
    end else begin
      bit fall, on, wr0;
      fall = k3 && !k2;
      wr0 = bus_wr && !bus_addr;
      on = (alarm_hit && m_we) || (fall && m_ke);
      if (on) m_pwr = 1;
      else if (wr0 && bus_wdata[3]) m_pwr = 0;
      if (alarm_hit) m_wf = 1; else if (wr0 && !bus_wdata[1]) m_wf = 0;
      if (fall) m_kf = 1; else if (wr0 && !bus_wdata[0]) m_kf = 0;
      if (bus_wr && bus_addr) begin m_we = bus_wdata[1]; m_ke = bus_wdata[0]; end
      k3 = k2; k2 = k1; k1 = kick_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic compare(input string req);
    bit [7:0] er;
    er = bus_addr ? {6'b0, m_we, m_ke} : {4'b0, !m_pwr, 1'b0, m_wf, m_kf};
    chk({req, " pwr"}, pwr_drive_low, m_pwr);
    chk({req, " irq"}, irq_drive_low,
        supply_ok && ((m_wf && m_we) || (m_kf && m_ke) || other_irq));
    chk({req, " rdata"}, bus_rdata, er);
  endtask

  task automatic cyc(input string req, input bit wr, input bit a, input bit [7:0] d,
                     input bit alm, input bit kn, input bit oth, input bit sup);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; alarm_hit = alm;
    kick_n = kn; other_irq = oth; supply_ok = sup;
    #1 compare(req);
  endtask

  task automatic idle(input string req, input bit a, input int n);
    for (int i = 0; i < n; i++) cyc(req, 0, a, 8'h00, 0, 1, 0, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cyc("R1 reset", 0, 0, 8'h00, 0, 1, 0, 1);
    cyc("R1 reset", 0, 1, 8'h00, 0, 1, 0, 1);
    @(negedge clk); rst_n = 1'b1;
    idle("R1 idle", 0, 2);
    // R9 enables, unused bits read zero
    cyc("R9 write en", 1, 1, 8'hFF, 0, 1, 0, 1);
    idle("R9 readback", 1, 1);
    cyc("R9 write en", 1, 1, 8'h02, 0, 1, 0, 1);
    idle("R9 readback", 1, 1);
    cyc("R9 write en", 1, 1, 8'h03, 0, 1, 0, 1);
    // R2 power off
    cyc("R2 off", 1, 0, 8'hFF, 0, 1, 0, 1);
    idle("R2 released", 0, 2);
    // R3 writing 0 to bit 3 does not re-enable
    cyc("R3 write0 pab", 1, 0, 8'h03, 0, 1, 0, 1);
    idle("R3 still off", 0, 1);
    // R3 R4 R6 alarm wakes
    cyc("R3 alarm", 0, 0, 8'h00, 1, 1, 0, 1);
    idle("R3 R6 woke", 0, 2);
    // R5 write 1 keeps flag; write 0 clears
    cyc("R5 write1", 1, 0, 8'h03, 0, 1, 0, 1);
    idle("R5 kept", 0, 1);
    cyc("R5 clear", 1, 0, 8'h01, 0, 1, 0, 1);
    idle("R5 cleared", 0, 1);
    // R8 kickstart via synchronizer, held low, then released
    cyc("R2 off again", 1, 0, 8'h08, 0, 1, 0, 1);
    for (int i = 0; i < 6; i++) cyc("R8 kick low", 0, 0, 8'h00, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc("R8 kick high", 0, 0, 8'h00, 0, 1, 0, 1);
    cyc("R8 clear kf", 1, 0, 8'h00, 0, 1, 0, 1);
    idle("R8 no event on rise", 0, 3);
    // R4 disabled events set flags only
    cyc("R4 disable", 1, 1, 8'h00, 0, 1, 0, 1);
    cyc("R4 off", 1, 0, 8'h08, 0, 1, 0, 1);
    cyc("R4 alarm dis", 0, 0, 8'h00, 1, 1, 0, 1);
    for (int i = 0; i < 4; i++) cyc("R4 kick dis", 0, 0, 8'h00, 0, 0, 0, 1);
    idle("R4 stay off", 0, 3);
    // R5 event beats clear in the same cycle
    cyc("R5 clash", 1, 0, 8'h00, 1, 1, 0, 1);
    idle("R5 set wins", 0, 1);
    // R6 R7 interrupt gating
    cyc("R6 enable", 1, 1, 8'h03, 0, 1, 0, 1);
    idle("R6 pending", 0, 1);
    cyc("R7 supply low", 0, 0, 8'h00, 0, 1, 0, 0);
    cyc("R7 supply low alarm", 0, 0, 8'h00, 1, 1, 1, 0);
    cyc("R7 supply low", 0, 0, 8'h00, 0, 1, 1, 0);
    cyc("R7 back", 0, 0, 8'h00, 0, 1, 0, 1);
    cyc("R6 clear", 1, 0, 8'h00, 0, 1, 0, 1);
    cyc("R6 other only", 0, 0, 8'h00, 0, 1, 1, 1);
    cyc("R6 other low", 0, 0, 8'h00, 0, 1, 0, 1);
    // R10 event with power-off write in same cycle
    cyc("R10 clash", 1, 0, 8'h08, 1, 1, 0, 1);
    idle("R10 stays on", 0, 2);
    cyc("R10 kick prep", 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R10 kick sync", 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R10 kick clash", 1, 0, 8'h08, 0, 0, 0, 1);
    idle("R10 stays on", 0, 2);
    idle("R9 final", 1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule